// File: doc/BRIEF.md
# Frame Character Count Tracker

This block keeps the per-frame character counts for the receive and transmit sides of a serial controller. Each side has its own down-counter. The receive counter is preset when a frame opens and steps down once for each character taken in. When the frame closes, the value left in the counter is queued, together with a status word, in a small FIFO. Software later pops that FIFO to learn the length and outcome of each frame.

The transmit counter is preset when an outgoing frame opens. It steps down once for each word written into the transmit data FIFO, not once for each character placed on the line. When the count has run out and the transmitter reports that the final byte has left, the block sends a one-cycle request to the framer to close the frame, for example by appending the check sequence and the closing flag. Either counter can be reloaded by software in the middle of a frame.

The receive side has two states. In `RX_IDLE` no frame is open. In `RX_FRAME` a frame is open. The transition `rx_open` runs from either state to `RX_FRAME` on a frame start. The transition `rx_close` runs from `RX_FRAME` to `RX_IDLE` on a frame end that has no frame start in the same cycle.

The transmit side has three states. In `TX_IDLE` no frame is open. In `TX_ACTIVE` the count is non-zero. In `TX_EXHAUSTED` the count is zero and the block is waiting for the last byte. The transitions are:
- `tx_open`: from any state on a frame start, to `TX_ACTIVE`, or to `TX_EXHAUSTED` if the start value is zero.
- `tx_run_out`: from `TX_ACTIVE` to `TX_EXHAUSTED` when the count reaches zero.
- `tx_refill`: from `TX_EXHAUSTED` to `TX_ACTIVE` on a reload with a non-zero value.
- `tx_finish`: from `TX_EXHAUSTED` to `TX_IDLE` when the last byte is reported done. This transition raises the terminate pulse.

Top module: `frame_count_tracker`

## Requirements
- R1: After reset both counters read 0, the status FIFO is empty (level 0, valid low), and the overflow and terminate outputs are low.
- R2: A receive frame start loads `rx_start_val` into the receive counter in the next cycle and opens the frame. A frame start overrides a reload and a character arriving in the same cycle.
- R3: While a receive frame is open, each `rx_char` cycle lowers the receive counter by one. The counter holds at zero, and characters are ignored while no frame is open.
- R4: A reload on either side loads its reload value in the next cycle, mid-frame or not. The reload takes priority over a same-cycle decrement, but yields to a same-cycle frame start.
- R5: A frame end while a receive frame is open pushes one entry. The entry holds the residual count in bits 31:16 and `rx_status` in bits 15:0. The residual is the count after that cycle's reload or character, not counting a same-cycle frame start. A frame end with no frame open is ignored.
- R6: The FIFO hands out entries oldest first on `fifo_count_out` and `fifo_status_out`. Each `fifo_pop` with valid high removes one entry. A pop on an empty FIFO is ignored. `fifo_level` always equals the number of stored entries, up to FIFO_DEPTH (default 4).
- R7: A push into a full FIFO with no pop in the same cycle is dropped. The stored entries are left unchanged, and `fifo_overflow` is high for exactly the next cycle. A push into a full FIFO with a same-cycle pop is accepted.
- R8: A transmit frame start loads `tx_start_val` in the next cycle. While a transmit frame is open, each `tx_fifo_write` lowers the count by one and holds it at zero. Writes while no frame is open are ignored.
- R9: `tx_terminate` is high for one cycle, the cycle after `tx_byte_done` is seen while a transmit frame is open with a count of zero. After the pulse the frame is closed. `tx_byte_done` has no effect while the count is non-zero or no frame is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_frame_start | input | 1 | Receive frame opens |
| rx_start_val | input | CNT_W | Programmable receive preset |
| rx_char | input | 1 | One character received |
| rx_frame_end | input | 1 | Receive frame closes |
| rx_status | input | 16 | Frame status word stored with the residual |
| rx_reload | input | 1 | Software reload of the receive counter |
| rx_reload_val | input | CNT_W | Receive reload value |
| rx_count | output | CNT_W | Current receive count |
| fifo_pop | input | 1 | Remove the oldest status entry |
| fifo_valid | output | 1 | FIFO holds at least one entry |
| fifo_count_out | output | CNT_W | Residual count of the oldest entry |
| fifo_status_out | output | 16 | Status word of the oldest entry |
| fifo_level | output | $clog2(FIFO_DEPTH+1) | Number of stored entries |
| fifo_overflow | output | 1 | One-cycle pulse: an entry was dropped |
| tx_frame_start | input | 1 | Transmit frame opens |
| tx_start_val | input | CNT_W | Transmit preset |
| tx_fifo_write | input | 1 | One word written into the transmit data FIFO |
| tx_reload | input | 1 | Software reload of the transmit counter |
| tx_reload_val | input | CNT_W | Transmit reload value |
| tx_byte_done | input | 1 | Transmitter finished sending a byte |
| tx_count | output | CNT_W | Current transmit count |
| tx_terminate | output | 1 | One-cycle request to close the frame |

## Verification
The hardest situation to reach from the ports is a frame end that arrives while the FIFO is full and software pops in the very same cycle. The push must then be accepted rather than flagged. A close second is a transmit reload landing in the same cycle as a write at a count of one. To reach both, the stimulus uses two long random phases. In the first, pops are rare, so the FIFO sits at its limit for long stretches. In the second, pops are frequent, so frame ends, pops and reloads collide often. Start and reload values are kept small, so both counters hit zero many times. Short directed sequences before the random phases pin down the priority of frame start over reload, and of reload over decrement.

// File: rtl/fct_pkg.sv
package fct_pkg;

    typedef enum logic {
        RX_IDLE,
        RX_FRAME
    } rx_state_e;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_ACTIVE,
        TX_EXHAUSTED
    } tx_state_e;

endpackage

// File: rtl/rx_count_unit.sv
module rx_count_unit
    import fct_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic [CNT_W-1:0] start_val,
    input  logic             char_in,
    input  logic             frame_end,
    input  logic             reload,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] count,
    output logic             push,
    output logic [CNT_W-1:0] push_val
);

    rx_state_e        state_q;
    rx_state_e        state_d;
    logic [CNT_W-1:0] upd;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RX_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state: rx_open / rx_close
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE: begin
                if (frame_start) begin
                    state_d = RX_FRAME;
                end
            end
            RX_FRAME: begin
                if (frame_start) begin
                    state_d = RX_FRAME;
                end else if (frame_end) begin
                    state_d = RX_IDLE;
                end
            end
            default: state_d = RX_IDLE;
        endcase
    end

    // count after reload or character, before any frame start
    always_comb begin
        upd = count;
        if (reload) begin
            upd = reload_val;
        end else if (char_in && (state_q == RX_FRAME) && (count != '0)) begin
            upd = count - 1'b1;
        end
    end

    assign push     = frame_end && (state_q == RX_FRAME);
    assign push_val = upd;

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (frame_start) begin
            count <= start_val;
        end else begin
            count <= upd;
        end
    end

endmodule

// File: rtl/tx_count_unit.sv
module tx_count_unit
    import fct_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic [CNT_W-1:0] start_val,
    input  logic             fifo_write,
    input  logic             reload,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             byte_done,
    output logic [CNT_W-1:0] count,
    output logic             terminate
);

    tx_state_e        state_q;
    tx_state_e        state_d;
    logic [CNT_W-1:0] upd;
    logic [CNT_W-1:0] count_d;
    logic             finish;

    always_comb begin
        upd = count;
        if (reload) begin
            upd = reload_val;
        end else if (fifo_write && (state_q != TX_IDLE) && (count != '0)) begin
            upd = count - 1'b1;
        end
    end

    assign finish  = (state_q == TX_EXHAUSTED) && byte_done;
    assign count_d = frame_start ? start_val : upd;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state: tx_open, tx_run_out, tx_refill, tx_finish
    always_comb begin
        state_d = state_q;
        if (frame_start) begin
            state_d = (start_val == '0) ? TX_EXHAUSTED : TX_ACTIVE;
        end else begin
            unique case (state_q)
                TX_IDLE: state_d = TX_IDLE;
                TX_ACTIVE: begin
                    state_d = (upd == '0) ? TX_EXHAUSTED : TX_ACTIVE;
                end
                TX_EXHAUSTED: begin
                    if (finish) begin
                        state_d = TX_IDLE;
                    end else if (upd != '0) begin
                        state_d = TX_ACTIVE;
                    end
                end
                default: state_d = TX_IDLE;
            endcase
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count     <= '0;
            terminate <= 1'b0;
        end else begin
            count     <= count_d;
            terminate <= finish;
        end
    end

endmodule

// File: rtl/status_fifo.sv
module status_fifo #(
    parameter int DEPTH  = 4,
    parameter int DATA_W = 32,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic              valid,
    output logic [LVL_W-1:0]  level,
    output logic              overflow
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;
    logic              pop_eff;
    logic              full;
    logic              push_ok;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (level == LVL_W'(DEPTH));
    assign pop_eff = pop && (level != '0);
    assign push_ok = push && (!full || pop_eff);
    assign valid   = (level != '0);
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            level    <= '0;
            overflow <= 1'b0;
        end else begin
            overflow <= push && !push_ok;
            if (push_ok) begin
                wr_ptr <= bump(wr_ptr);
            end
            if (pop_eff) begin
                rd_ptr <= bump(rd_ptr);
            end
            if (push_ok && !pop_eff) begin
                level <= level + 1'b1;
            end else if (pop_eff && !push_ok) begin
                level <= level - 1'b1;
            end
        end
    end

endmodule

// File: rtl/frame_count_tracker.sv
module frame_count_tracker #(
    parameter int CNT_W      = 16,
    parameter int FIFO_DEPTH = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            rx_frame_start,
    input  logic [CNT_W-1:0]                rx_start_val,
    input  logic                            rx_char,
    input  logic                            rx_frame_end,
    input  logic [15:0]                     rx_status,
    input  logic                            rx_reload,
    input  logic [CNT_W-1:0]                rx_reload_val,
    output logic [CNT_W-1:0]                rx_count,
    input  logic                            fifo_pop,
    output logic                            fifo_valid,
    output logic [CNT_W-1:0]                fifo_count_out,
    output logic [15:0]                     fifo_status_out,
    output logic [$clog2(FIFO_DEPTH+1)-1:0] fifo_level,
    output logic                            fifo_overflow,
    input  logic                            tx_frame_start,
    input  logic [CNT_W-1:0]                tx_start_val,
    input  logic                            tx_fifo_write,
    input  logic                            tx_reload,
    input  logic [CNT_W-1:0]                tx_reload_val,
    input  logic                            tx_byte_done,
    output logic [CNT_W-1:0]                tx_count,
    output logic                            tx_terminate
);

    localparam int ENTRY_W = CNT_W + 16;

    logic               rx_push;
    logic [CNT_W-1:0]   rx_push_val;
    logic [ENTRY_W-1:0] fifo_head;

    rx_count_unit #(.CNT_W(CNT_W)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_start(rx_frame_start),
        .start_val  (rx_start_val),
        .char_in    (rx_char),
        .frame_end  (rx_frame_end),
        .reload     (rx_reload),
        .reload_val (rx_reload_val),
        .count      (rx_count),
        .push       (rx_push),
        .push_val   (rx_push_val)
    );

    status_fifo #(.DEPTH(FIFO_DEPTH), .DATA_W(ENTRY_W)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (rx_push),
        .push_data({rx_push_val, rx_status}),
        .pop      (fifo_pop),
        .head     (fifo_head),
        .valid    (fifo_valid),
        .level    (fifo_level),
        .overflow (fifo_overflow)
    );

    assign fifo_count_out  = fifo_head[ENTRY_W-1:16];
    assign fifo_status_out = fifo_head[15:0];

    tx_count_unit #(.CNT_W(CNT_W)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_start(tx_frame_start),
        .start_val  (tx_start_val),
        .fifo_write (tx_fifo_write),
        .reload     (tx_reload),
        .reload_val (tx_reload_val),
        .byte_done  (tx_byte_done),
        .count      (tx_count),
        .terminate  (tx_terminate)
    );

endmodule

// File: rtl/fct_checker.sv
module fct_checker #(
    parameter int CNT_W      = 16,
    parameter int FIFO_DEPTH = 4
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            rx_frame_start,
    input logic [CNT_W-1:0]                rx_start_val,
    input logic                            rx_reload,
    input logic [CNT_W-1:0]                rx_reload_val,
    input logic                            rx_frame_end,
    input logic [CNT_W-1:0]                rx_count,
    input logic                            fifo_pop,
    input logic                            fifo_valid,
    input logic [$clog2(FIFO_DEPTH+1)-1:0] fifo_level,
    input logic                            fifo_overflow,
    input logic                            tx_frame_start,
    input logic                            tx_reload,
    input logic                            tx_byte_done,
    input logic [CNT_W-1:0]                tx_count,
    input logic                            tx_terminate
);

    p_rx_start_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_frame_start |=> rx_count == $past(rx_start_val));

    p_rx_no_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_frame_start && !rx_reload) |=> rx_count <= $past(rx_count));

    p_rx_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_reload && !rx_frame_start) |=> rx_count == $past(rx_reload_val));

    p_level_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_level <= ($clog2(FIFO_DEPTH+1))'(FIFO_DEPTH));

    p_pop_drains_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_pop && fifo_valid && !rx_frame_end) |=> fifo_level == $past(fifo_level) - 1'b1);

    p_overflow_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_overflow |-> (fifo_level == ($clog2(FIFO_DEPTH+1))'(FIFO_DEPTH))
                          && ($past(fifo_level) == ($clog2(FIFO_DEPTH+1))'(FIFO_DEPTH)));

    p_tx_no_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_frame_start && !tx_reload) |=> tx_count <= $past(tx_count));

    p_term_at_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_terminate |-> ($past(tx_count) == '0) && $past(tx_byte_done));

endmodule

bind frame_count_tracker fct_checker #(.CNT_W(CNT_W), .FIFO_DEPTH(FIFO_DEPTH)) u_fct_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .rx_frame_start(rx_frame_start),
    .rx_start_val  (rx_start_val),
    .rx_reload     (rx_reload),
    .rx_reload_val (rx_reload_val),
    .rx_frame_end  (rx_frame_end),
    .rx_count      (rx_count),
    .fifo_pop      (fifo_pop),
    .fifo_valid    (fifo_valid),
    .fifo_level    (fifo_level),
    .fifo_overflow (fifo_overflow),
    .tx_frame_start(tx_frame_start),
    .tx_reload     (tx_reload),
    .tx_byte_done  (tx_byte_done),
    .tx_count      (tx_count),
    .tx_terminate  (tx_terminate)
);

// File: tb/frame_count_tracker_bench.sv
module frame_count_tracker_bench;

    localparam int DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_frame_start = 0, rx_char = 0, rx_frame_end = 0, rx_reload = 0;
    logic [15:0] rx_start_val = 0, rx_status = 0, rx_reload_val = 0;
    logic        fifo_pop = 0;
    logic        tx_frame_start = 0, tx_fifo_write = 0, tx_reload = 0, tx_byte_done = 0;
    logic [15:0] tx_start_val = 0, tx_reload_val = 0;
    logic [15:0] rx_count, tx_count, fifo_count_out, fifo_status_out;
    logic [2:0]  fifo_level;
    logic        fifo_valid, fifo_overflow, tx_terminate;

    int total = 0;
    int bad   = 0;

    frame_count_tracker #(.CNT_W(16), .FIFO_DEPTH(DEPTH)) u_frame_count_tracker (.*);

    always #4 clk = ~clk;

    // behavioural reference
    int          m_rx, m_tx, m_tx_st;  // tx: 0 idle, 1 open nonzero, 2 open zero
    bit          m_rx_open, m_ovf, m_term;
    logic [31:0] mq[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_rx = 0; m_tx = 0; m_tx_st = 0; m_rx_open = 0; m_ovf = 0; m_term = 0;
            mq.delete();
        end else begin
            int  r_upd, t_upd;
            bit  pushing, popping;
            r_upd = rx_reload ? int'(rx_reload_val)
                  : ((rx_char && m_rx_open && m_rx > 0) ? m_rx - 1 : m_rx);
            pushing = rx_frame_end && m_rx_open;
            popping = fifo_pop && (mq.size() > 0);
            if (popping) void'(mq.pop_front());
            m_ovf = 0;
            if (pushing) begin
                if (mq.size() >= DEPTH) m_ovf = 1;
                else mq.push_back({r_upd[15:0], rx_status});
            end
            m_rx = rx_frame_start ? int'(rx_start_val) : r_upd;
            m_rx_open = rx_frame_start ? 1'b1 : (rx_frame_end ? 1'b0 : m_rx_open);

            t_upd = tx_reload ? int'(tx_reload_val)
                  : ((tx_fifo_write && m_tx_st != 0 && m_tx > 0) ? m_tx - 1 : m_tx);
            m_term = (m_tx_st == 2) && tx_byte_done;
            if (tx_frame_start) begin
                m_tx = tx_start_val;
                m_tx_st = (tx_start_val == 0) ? 2 : 1;
            end else begin
                m_tx = t_upd;
                if (m_term) m_tx_st = 0;
                else if (m_tx_st != 0) m_tx_st = (t_upd == 0) ? 2 : 1;
            end
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        check("R3", "rx_count", rx_count, m_rx);
        check("R8", "tx_count", tx_count, m_tx);
        check("R6", "fifo_level", fifo_level, mq.size());
        check("R6", "fifo_valid", fifo_valid, mq.size() != 0);
        if (mq.size() != 0) begin
            check("R5", "head residual", fifo_count_out, mq[0][31:16]);
            check("R5", "head status", fifo_status_out, mq[0][15:0]);
        end
        check("R7", "fifo_overflow", fifo_overflow, m_ovf);
        check("R9", "tx_terminate", tx_terminate, m_term);
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle_inputs();
        rx_frame_start = 0; rx_char = 0; rx_frame_end = 0; rx_reload = 0;
        fifo_pop = 0; tx_frame_start = 0; tx_fifo_write = 0; tx_reload = 0; tx_byte_done = 0;
    endtask

    task automatic report();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1", "rx_count reset", rx_count, 0);
        check("R1", "tx_count reset", tx_count, 0);
        check("R1", "level reset", fifo_level, 0);
        check("R1", "valid reset", fifo_valid, 0);
        check("R1", "overflow reset", fifo_overflow, 0);
        check("R1", "terminate reset", tx_terminate, 0);

        // R2: frame start beats reload and char
        rx_frame_start = 1; rx_start_val = 5; rx_reload = 1; rx_reload_val = 9; rx_char = 1;
        tick(); idle_inputs();
        check("R2", "start wins", rx_count, 5);
        // R4: reload beats decrement mid-frame
        rx_reload = 1; rx_reload_val = 9; rx_char = 1;
        tick(); idle_inputs();
        check("R4", "rx reload over char", rx_count, 9);
        // R5: end with same-cycle char stores count after char
        rx_char = 1; rx_frame_end = 1; rx_status = 16'hA5C3;
        tick(); idle_inputs();
        check("R5", "residual", fifo_count_out, 8);
        check("R5", "status", fifo_status_out, 16'hA5C3);
        // R5: end with no frame open ignored
        rx_frame_end = 1;
        tick(); idle_inputs();
        check("R5", "stray end ignored", fifo_level, 1);
        // R6: pop empties, second pop ignored
        fifo_pop = 1; tick(); tick(); idle_inputs();
        check("R6", "pop to empty", fifo_level, 0);

        // R8/R9: tx start 2, writes, terminate
        tx_frame_start = 1; tx_start_val = 2; tx_reload = 1; tx_reload_val = 7;
        tick(); idle_inputs();
        check("R4", "tx start beats reload", tx_count, 2);
        tx_byte_done = 1; tick(); idle_inputs();
        check("R9", "no terminate while nonzero", tx_terminate, 0);
        tx_fifo_write = 1; tick(); tick(); tick(); idle_inputs();
        check("R8", "tx floor zero", tx_count, 0);
        tx_byte_done = 1; tick(); idle_inputs();
        check("R9", "terminate pulse", tx_terminate, 1);
        tick();
        check("R9", "terminate one cycle", tx_terminate, 0);

        // random phases: sparse then dense pops
        for (int ph = 0; ph < 2; ph++) begin
            for (int i = 0; i < 4000; i++) begin
                rx_frame_start = ($urandom_range(0, 11) == 0);
                rx_start_val   = 16'($urandom_range(0, 6));
                rx_char        = $urandom_range(0, 1);
                rx_frame_end   = ($urandom_range(0, 5) == 0);
                rx_status      = 16'($urandom);
                rx_reload      = ($urandom_range(0, 19) == 0);
                rx_reload_val  = 16'($urandom_range(0, 4));
                fifo_pop       = (ph == 0) ? ($urandom_range(0, 15) == 0) : ($urandom_range(0, 1) == 1);
                tx_frame_start = ($urandom_range(0, 14) == 0);
                tx_start_val   = 16'($urandom_range(0, 5));
                tx_fifo_write  = $urandom_range(0, 1);
                tx_reload      = ($urandom_range(0, 19) == 0);
                tx_reload_val  = 16'($urandom_range(0, 3));
                tx_byte_done   = ($urandom_range(0, 2) == 0);
                tick();
            end
        end
        idle_inputs();
        tick();
        report();
    end

endmodule